// File: doc/BRIEF.md
# Predicated Strided Segment Load Address Generator

This block turns one vector load command into a stream of memory requests. Each request carries a byte address, a destination register number and an element index. A single command covers four load forms: unit-stride, constant-stride, indexed, and segmented. In the segmented form every element consists of several consecutive fields, and each field goes to its own destination register. A predicate mask can switch individual elements off. Elements that are switched off produce no request.

A command is accepted by pulsing `start` while the block is idle. The block captures every command input at that edge. It then emits requests one per cycle, and only moves on when a request is accepted through the valid/ready handshake. After the last accepted request it raises `done` for one cycle.

Memory access and the return of load data are handled elsewhere.

Top module: `seg_load_agu`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_valid`, `done` and `busy` are all 0.
- R2: When `unit_stride` is 1, the stride used for all address arithmetic equals `elem_size`.
- R3: When `unit_stride` is 0, the stride is `stride_val`. In non-indexed mode, element i, field j is fetched from `base_addr + i*(seglen+1)*stride + j*stride`.
- R4: When `idx_mode` is 1, element i's offset is taken from `idx_offsets[i*AW +: AW]`. The address of field j is then `base_addr + offset_i + j*stride`.
- R5: Each emitted element produces exactly `seglen+1` requests, with fields j = 0..seglen. Field j reports `req_reg = dest_reg + j` modulo 2^RW, and `req_elem = i`.
- R6: When `pred_en` is 1, element i is emitted only if `pred_mask[i] XOR pred_inv` is 1.
- R7: When `pred_en` is 0, every element 0..VL-1 is emitted. A `vl` above MAXVL is treated as MAXVL.
- R8: Requests come out in ascending element order, with fields ascending inside each element. While `req_valid` is high and `req_ready` is low, the request holds steady.
- R9: Address arithmetic wraps modulo 2^AW.
- R10: `done` is a one-cycle pulse, with `req_valid` low. It occurs in the cycle after the final accepted request. When no element is eligible (VL of zero or everything masked), it occurs in the cycle after `start`, with no request emitted. `busy` is low again in the following cycle.
- R11: A `start` pulse while `busy` is high is ignored, and changes to the command inputs during a run do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| base_addr | input | AW | Base byte address |
| elem_size | input | AW | Element size in bytes (stride in unit mode) |
| stride_val | input | AW | Scalar stride value for constant-stride mode |
| unit_stride | input | 1 | 1: stride = elem_size |
| idx_mode | input | 1 | 1: offset source is vectorised (indexed load) |
| idx_offsets | input | MAXVL*AW | Per-element offsets, element i at bits i*AW |
| seglen | input | SEGW | Fields per element minus one |
| vl | input | VLW | Vector length |
| dest_reg | input | RW | First destination register |
| pred_mask | input | MAXVL | Per-element predicate bits |
| pred_en | input | 1 | Enable predication |
| pred_inv | input | 1 | Invert predicate bits |
| req_ready | input | 1 | Downstream accepts the request |
| req_valid | output | 1 | Request present |
| req_addr | output | AW | Request byte address |
| req_reg | output | RW | Destination register of the request |
| req_elem | output | IW | Element index of the request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions guard the properties that are local in time:
- a stalled request keeps its element, field and address;
- the field counter never passes the segment length;
- every emitted element is one that was eligible at start;
- `done` is a lone pulse with no request beside it.

The bench's scenarios are needed for everything else. They show the actual address values of the unit, constant-stride, indexed and wrapping cases, and the exact element skipping under normal and inverted predicates. They also show the full ordering, the register wrap, the clamping of VL, the timing of `done` for empty commands, and the rejection of a mid-run `start`.

// File: rtl/seg_load_pkg.sv
// Shared types for the segment load address generator.
package seg_load_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } agu_state_e;
endpackage

// File: rtl/seg_load_pick.sv
// Lowest-set-bit finder over an N-bit element mask.
// Assumes nothing about the mask; found is 0 when the mask is empty.
module seg_load_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mask[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/seg_load_addr.sv
// Combinational address former for one (element, field) pair.
// Assumes the configuration inputs are held stable by the caller; all sums wrap at AW bits.
module seg_load_addr #(
    parameter int AW   = 32,
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter int SEGW = 3
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   esize,
    input  logic [AW-1:0]   strv,
    input  logic            unit,
    input  logic            indexed,
    input  logic [N*AW-1:0] offsets,
    input  logic [SEGW-1:0] seglen,
    input  logic [IW-1:0]   elem,
    input  logic [SEGW-1:0] field,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] stride_eff;
    logic [AW-1:0] seg_cnt;
    logic [AW-1:0] off_elem;
    logic [AW-1:0] off_field;

    // Select the stride, form element and field offsets, then sum.
    always_comb begin
        stride_eff = unit ? esize : strv;
        seg_cnt    = AW'(seglen) + AW'(1);
        if (indexed)
            off_elem = offsets[elem*AW +: AW];
        else
            off_elem = AW'(elem) * seg_cnt * stride_eff;
        off_field  = AW'(field) * stride_eff;
        addr       = base + off_elem + off_field;
    end
endmodule

// File: rtl/seg_load_seq.sv
// Element/field sequencer: walks eligible elements in ascending order and the
// fields of each, advancing only on an accepted handshake.
// Assumes accept is only raised while idle.
module seg_load_seq
    import seg_load_pkg::*;
#(
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter int SEGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [N-1:0]    elig_in,
    input  logic [SEGW-1:0] seglen_in,
    input  logic            req_ready,
    output logic            req_valid,
    output logic [IW-1:0]   elem,
    output logic [SEGW-1:0] field,
    output logic [SEGW-1:0] seglen_q,
    output logic            busy,
    output logic            done
);
    agu_state_e      state_q;
    logic [N-1:0]    elig_q;
    logic [IW-1:0]   elem_q;
    logic [SEGW-1:0] field_q;
    logic [N-1:0]    lower_incl;
    logic [N-1:0]    above;
    logic            first_found, nxt_found;
    logic [IW-1:0]   first_idx, nxt_idx;
    logic            hs;

    // Mask of eligible elements strictly above the current one.
    always_comb begin
        lower_incl = (N'(2) << elem_q) - N'(1);
        above      = elig_q & ~lower_incl;
    end

    seg_load_pick #(.N(N), .IW(IW)) first_pick_i (
        .mask(elig_in), .found(first_found), .idx(first_idx)
    );

    seg_load_pick #(.N(N), .IW(IW)) next_pick_i (
        .mask(above), .found(nxt_found), .idx(nxt_idx)
    );

    assign hs        = (state_q == ST_RUN) && req_ready;
    assign req_valid = (state_q == ST_RUN);
    assign done      = (state_q == ST_DONE);
    assign busy      = (state_q != ST_IDLE);
    assign elem      = elem_q;
    assign field     = field_q;

    // Main state machine: capture at accept, step field then element on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            elig_q   <= '0;
            elem_q   <= '0;
            field_q  <= '0;
            seglen_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        elig_q   <= elig_in;
                        seglen_q <= seglen_in;
                        field_q  <= '0;
                        elem_q   <= first_idx;
                        state_q  <= first_found ? ST_RUN : ST_DONE;
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        if (field_q == seglen_q) begin
                            field_q <= '0;
                            if (nxt_found) elem_q  <= nxt_idx;
                            else           state_q <= ST_DONE;
                        end else begin
                            field_q <= field_q + SEGW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(elem_q) && $stable(field_q)));

    // R5
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (field_q <= seglen_q));

    // R6
    elig_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> elig_q[elem_q]);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/seg_load_agu.sv
// Top: captures a vector load command at start and streams address/register/element
// requests for unit-stride, constant-stride, indexed and segmented forms with predication.
// Assumes downstream honours valid/ready; memory access is elsewhere.
module seg_load_agu #(
    parameter int AW    = 32,
    parameter int MAXVL = 8,
    parameter int SEGW  = 3,
    parameter int RW    = 5,
    localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       base_addr,
    input  logic [AW-1:0]       elem_size,
    input  logic [AW-1:0]       stride_val,
    input  logic                unit_stride,
    input  logic                idx_mode,
    input  logic [MAXVL*AW-1:0] idx_offsets,
    input  logic [SEGW-1:0]     seglen,
    input  logic [VLW-1:0]      vl,
    input  logic [RW-1:0]       dest_reg,
    input  logic [MAXVL-1:0]    pred_mask,
    input  logic                pred_en,
    input  logic                pred_inv,
    input  logic                req_ready,
    output logic                req_valid,
    output logic [AW-1:0]       req_addr,
    output logic [RW-1:0]       req_reg,
    output logic [IW-1:0]       req_elem,
    output logic                busy,
    output logic                done
);
    logic                accept;
    logic [MAXVL-1:0]    elig_in;
    logic [AW-1:0]       base_q, esize_q, strv_q;
    logic                unit_q, idx_q;
    logic [MAXVL*AW-1:0] offs_q;
    logic [RW-1:0]       rd_q;
    logic [IW-1:0]       cur_elem;
    logic [SEGW-1:0]     cur_field;
    logic [SEGW-1:0]     seg_q;

    assign accept = start && !busy;

    // Per-element eligibility from VL bound and the (optionally inverted) predicate.
    for (genvar gi = 0; gi < MAXVL; gi++) begin : g_elig
        assign elig_in[gi] = (vl > VLW'(gi)) && (!pred_en || (pred_mask[gi] ^ pred_inv));
    end

    // Capture the address-side configuration when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            esize_q <= '0;
            strv_q  <= '0;
            unit_q  <= 1'b0;
            idx_q   <= 1'b0;
            offs_q  <= '0;
            rd_q    <= '0;
        end else if (accept) begin
            base_q  <= base_addr;
            esize_q <= elem_size;
            strv_q  <= stride_val;
            unit_q  <= unit_stride;
            idx_q   <= idx_mode;
            offs_q  <= idx_offsets;
            rd_q    <= dest_reg;
        end
    end

    seg_load_seq #(.N(MAXVL), .IW(IW), .SEGW(SEGW)) seq_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .elig_in(elig_in),
        .seglen_in(seglen), .req_ready(req_ready), .req_valid(req_valid),
        .elem(cur_elem), .field(cur_field), .seglen_q(seg_q),
        .busy(busy), .done(done)
    );

    seg_load_addr #(.AW(AW), .N(MAXVL), .IW(IW), .SEGW(SEGW)) addr_i (
        .base(base_q), .esize(esize_q), .strv(strv_q), .unit(unit_q),
        .indexed(idx_q), .offsets(offs_q), .seglen(seg_q),
        .elem(cur_elem), .field(cur_field), .addr(req_addr)
    );

    assign req_reg  = rd_q + RW'(cur_field);
    assign req_elem = cur_elem;

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_reg)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

// File: tb/seg_load_agu_tb_top.sv
// Bench: behavioural queue model of the expected request stream, compared every cycle.
module seg_load_agu_tb_top;
    localparam int AW = 32, MAXVL = 8, SEGW = 3, RW = 5, IW = 3, VLW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0]       base_addr = '0, elem_size = '0, stride_val = '0;
    logic                unit_stride = 1'b0, idx_mode = 1'b0;
    logic [MAXVL*AW-1:0] idx_offsets = '0;
    logic [SEGW-1:0]     seglen = '0;
    logic [VLW-1:0]      vl = '0;
    logic [RW-1:0]       dest_reg = '0;
    logic [MAXVL-1:0]    pred_mask = '0;
    logic                pred_en = 1'b0, pred_inv = 1'b0, req_ready = 1'b0;
    logic                req_valid, busy, done;
    logic [AW-1:0]       req_addr;
    logic [RW-1:0]       req_reg;
    logic [IW-1:0]       req_elem;

    seg_load_agu dut_i (.*);

    int checks = 0, errors = 0, cycles = 0;
    logic [AW-1:0] q_addr[$];
    logic [RW-1:0] q_reg[$];
    logic [IW-1:0] q_elem[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Build the expected stream from the current command inputs.
    task automatic build_model();
        int n;
        logic [AW-1:0] stride, off;
        q_addr.delete(); q_reg.delete(); q_elem.delete();
        n = (int'(vl) > MAXVL) ? MAXVL : int'(vl);
        stride = unit_stride ? elem_size : stride_val;
        for (int i = 0; i < n; i++) begin
            if (!pred_en || (pred_mask[i] ^ pred_inv)) begin
                for (int j = 0; j <= int'(seglen); j++) begin
                    if (idx_mode) off = idx_offsets[i*AW +: AW];
                    else off = AW'(i) * (AW'(seglen) + 1) * stride;
                    q_addr.push_back(base_addr + off + AW'(j) * stride);
                    q_reg.push_back(dest_reg + RW'(j));
                    q_elem.push_back(IW'(i));
                end
            end
        end
    endtask

    task automatic run_case(input logic [AW-1:0] b, input logic [AW-1:0] es,
                            input logic [AW-1:0] sv, input bit un, input bit ix,
                            input int sg, input int v, input int rd,
                            input logic [7:0] mk, input bit pe, input bit pi,
                            input string tag, input bit poke);
        bit exp_done, rdy;
        int step;
        @(negedge clk);
        base_addr = b; elem_size = es; stride_val = sv; unit_stride = un;
        idx_mode = ix; seglen = SEGW'(sg); vl = VLW'(v); dest_reg = RW'(rd);
        pred_mask = mk; pred_en = pe; pred_inv = pi; start = 1'b1;
        build_model();
        exp_done = (q_addr.size() == 0);
        @(negedge clk);
        start = 1'b0;
        step = 0;
        forever begin
            chk(done === exp_done, "R10", {tag, " done"}, 32'(done), 32'(exp_done));
            if (exp_done) begin
                chk(req_valid === 1'b0, "R10", {tag, " valid at done"}, 32'(req_valid), 0);
                break;
            end
            rdy = ($urandom_range(0, 3) != 0);
            req_ready = rdy;
            chk(req_valid === 1'b1, "R8", {tag, " valid"}, 32'(req_valid), 1);
            chk(req_addr === q_addr[0], tag, "addr", req_addr, q_addr[0]);
            chk(req_reg === q_reg[0], "R5", {tag, " reg"}, 32'(req_reg), 32'(q_reg[0]));
            chk(req_elem === q_elem[0], "R8", {tag, " elem"}, 32'(req_elem), 32'(q_elem[0]));
            // R11: poke start with altered inputs mid-run
            if (poke && step == 1) begin
                start = 1'b1; base_addr = ~b; vl = 4'd1;
            end else begin
                start = 1'b0;
            end
            if (rdy) begin
                void'(q_addr.pop_front()); void'(q_reg.pop_front()); void'(q_elem.pop_front());
                if (q_addr.size() == 0) exp_done = 1'b1;
            end
            @(negedge clk);
            step++;
        end
        start = 1'b0; req_ready = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R10", {tag, " idle after done"}, 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_valid === 1'b0, "R1", "valid in reset", 32'(req_valid), 0);
        chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R1", "done after reset", 32'(done), 0);
        chk(req_valid === 1'b0, "R1", "valid after reset", 32'(req_valid), 0);

        run_case(32'h1000, 32'd4, 32'h999, 1, 0, 0, 5, 2, 8'h00, 0, 0, "R2", 0);
        run_case(32'h2000, 32'd4, 32'h40, 0, 0, 2, 3, 4, 8'h00, 0, 0, "R3", 0);
        run_case(32'h3000, 32'd2, 32'h8, 0, 0, 1, 8, 8, 8'b1010_0110, 1, 0, "R6", 0);
        run_case(32'h3000, 32'd2, 32'h8, 0, 0, 1, 8, 8, 8'b1010_0110, 1, 1, "R6", 0);
        for (int i = 0; i < MAXVL; i++) idx_offsets[i*AW +: AW] = AW'((7 - i) * 32'h100 + 3);
        run_case(32'h4000, 32'd8, 32'h0, 1, 1, 1, 6, 1, 8'b0011_1011, 1, 0, "R4", 0);
        run_case(32'h5000, 32'd4, 32'h4, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R10", 0);
        run_case(32'h5000, 32'd4, 32'h4, 0, 0, 0, 4, 0, 8'h00, 1, 0, "R10", 0);
        run_case(32'hFFFF_FFF0, 32'd4, 32'h10, 0, 0, 3, 4, 3, 8'h00, 0, 0, "R9", 0);
        run_case(32'h6000, 32'd4, 32'h0, 1, 0, 0, 12, 0, 8'h00, 0, 0, "R7", 0);
        run_case(32'h7000, 32'd4, 32'h20, 0, 0, 3, 4, 30, 8'h00, 0, 0, "R11", 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule